// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds wall-clock time and date as seven packed-BCD bytes: seconds, minutes, hours, day of month, weekday, month and a two-digit year. A divider counts pulses on a base tick input and, once per second, advances the seconds. Carries ripple up through minutes, hours, day, weekday, month and year. Day of month wraps at the length of the current month, and February has a leap day.

Software freezes counting with a stop input, writes any subset of the fields through per-field load enables, and then releases stop. While stop is high the sub-second divider is held at zero, so the first advance after release comes exactly one full second later. The hours byte can be read as 24-hour time or as 12-hour time with a PM bit. Bit 7 of the seconds byte is a sticky "time not trustworthy" flag. It is set at reset and whenever the oscillator-fail input is high. It clears only when software loads the seconds byte.

The load, stop and mode pins are plain level controls with no handshake. Each load takes effect on the clock edge that samples it, so there is no back-pressure.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset the bytes read seconds 0x80 (flag set, 00 s), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 and year 0x00.
- R2: Seconds advance by one on every SUBDIV-th tick_i pulse. Seconds wrap 59 to 00 with a carry into minutes, and minutes wrap 59 to 00 with a carry into hours. With no tick_i and no load the time does not change.
- R3: With mode12_i low, hours count 00 to 23 in BCD, and 23 wraps to 00 with a carry into the day.
- R4: With mode12_i high, hr_o bits 4:0 hold 01 to 12 in BCD and bit 5 is PM. 11 goes to 12 and toggles PM, 12 goes to 01 and keeps PM, and the day carry happens on the step from 11 PM to 12 AM.
- R5: The day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R6: February has 29 days when the year, read as a decimal number, is divisible by 4, and 28 days otherwise.
- R7: The weekday is binary 0 to 6. It increments on every day carry and wraps from 6 to 0.
- R8: While stop_i is high no time field changes unless it is loaded, and the divider is held at zero. After stop_i falls, the first advance needs SUBDIV further tick_i pulses.
- R9: ld_en_i bit i (0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month, 6 year) writes byte i of ld_val_i (bits 8i+7:8i). The written value is masked to 7, 7, 6, 6, 3, 5 and 8 bits respectively, and unused output bits read 0. A cycle with any load suppresses that cycle's advance and restarts the divider at zero.
- R10: sec_o bit 7 is set from reset. It is set on the clock edge after osc_fail_i is high and is cleared by a seconds load. When both happen in the same cycle, osc_fail_i wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base tick pulse, SUBDIV pulses per second |
| stop_i | input | 1 | Freeze counting and hold the divider at zero |
| mode12_i | input | 1 | 1 = 12-hour hours with PM bit, 0 = 24-hour |
| osc_fail_i | input | 1 | Oscillator failure indication, sets the sticky flag |
| ld_en_i | input | 7 | Per-field load enables |
| ld_val_i | input | 56 | Load data, one byte per field |
| sec_o | output | 8 | Flag and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hr_o | output | 8 | BCD hours (PM bit 5 in 12-hour mode) |
| day_o | output | 8 | BCD day of month |
| wday_o | output | 8 | Binary weekday 0 to 6 |
| mon_o | output | 8 | BCD month |
| yr_o | output | 8 | BCD year |

## Verification
The bench builds the block with SUBDIV set to 3 rather than the default of 2. This leaves two distinct partial divider states before a second completes. It therefore exposes a divider that is not cleared by stop or by a load, and an advance that fires one pulse early or late. With short seconds, the random runs can cross many minute, hour and month boundaries from loaded start points close to them.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

  // Field order on the load bus and the outputs
  localparam int NFIELDS = 7;
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HR    = 2;
  localparam int F_DAY   = 3;
  localparam int F_WDAY  = 4;
  localparam int F_MON   = 5;
  localparam int F_YR    = 6;

  // Stored width of each field
  localparam int W_SEC  = 7;
  localparam int W_MIN  = 7;
  localparam int W_HR   = 6;
  localparam int W_DAY  = 6;
  localparam int W_WDAY = 3;
  localparam int W_MON  = 5;
  localparam int W_YR   = 8;

  // Add one to a two-digit packed BCD value, without wrapping
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // Last day of the month, in BCD
  function automatic logic [5:0] month_len(input logic [4:0] mon, input logic [7:0] yr);
    logic [6:0] yb;
    logic [5:0] r;
    yb = bcd_to_bin(yr);
    case (mon)
      5'h02:                      r = (yb[1:0] == 2'b00) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bcd_tick_div.sv
module bcd_tick_div #(
  parameter int SUBDIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hold_i,
  input  logic clr_i,
  output logic adv_o
);
  localparam int CW = (SUBDIV > 1) ? $clog2(SUBDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SUBDIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign adv_o   = tick_i && at_last && !hold_i && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold_i || clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_last ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/bcd_wrap_counter.sv
// BCD (or small binary) counter that wraps from MAXV or above to MINV
module bcd_wrap_counter
  import bcd_clock_pkg::*;
#(
  parameter int             WIDTH = 7,
  parameter logic [WIDTH-1:0] MAXV  = WIDTH'(8'h59),
  parameter logic [WIDTH-1:0] MINV  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] ld_val_i,
  output logic [WIDTH-1:0] val_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] val_q;
  logic [WIDTH-1:0] nxt;
  logic             wrap;

  assign wrap    = (val_q >= MAXV);
  assign nxt     = wrap ? MINV : WIDTH'(bcd_inc(8'(val_q)));
  assign carry_o = inc_i && wrap;
  assign val_o   = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val_q <= MINV;
    else if (ld_i)  val_q <= ld_val_i;
    else if (inc_i) val_q <= nxt;
  end
endmodule

// File: rtl/bcd_hour_counter.sv
module bcd_hour_counter
  import bcd_clock_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_i,
  input  logic            mode12_i,
  input  logic            ld_i,
  input  logic [W_HR-1:0] ld_val_i,
  output logic [W_HR-1:0] hr_o,
  output logic            carry_o
);
  logic [W_HR-1:0] hr_q;
  logic [W_HR-1:0] nxt;
  logic            wrap;
  logic [4:0]      h12;
  logic            pm;

  assign h12 = hr_q[4:0];
  assign pm  = hr_q[5];

  always_comb begin
    nxt  = hr_q;
    wrap = 1'b0;
    if (mode12_i) begin
      if (h12 == 5'h11) begin
        // 11 -> 12 flips AM/PM; leaving 11 PM starts a new day
        nxt  = {~pm, 5'h12};
        wrap = pm;
      end else if (h12 >= 5'h12) begin
        nxt = {pm, 5'h01};
      end else begin
        nxt = {pm, 5'(bcd_inc(8'(h12)))};
      end
    end else begin
      if (hr_q >= 6'h23) begin
        nxt  = '0;
        wrap = 1'b1;
      end else begin
        nxt = 6'(bcd_inc(8'(hr_q)));
      end
    end
  end

  assign carry_o = inc_i && wrap;
  assign hr_o    = hr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hr_q <= '0;
    else if (ld_i)  hr_q <= ld_val_i;
    else if (inc_i) hr_q <= nxt;
  end
endmodule

// File: rtl/bcd_date_counter.sv
module bcd_date_counter
  import bcd_clock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic [3:0]        ld_i,      // day, weekday, month, year
  input  logic [W_DAY-1:0]  ld_day_i,
  input  logic [W_WDAY-1:0] ld_wday_i,
  input  logic [W_MON-1:0]  ld_mon_i,
  input  logic [W_YR-1:0]   ld_yr_i,
  output logic [W_DAY-1:0]  day_o,
  output logic [W_WDAY-1:0] wday_o,
  output logic [W_MON-1:0]  mon_o,
  output logic [W_YR-1:0]   yr_o
);
  logic [W_DAY-1:0] day_q;
  logic [W_DAY-1:0] last_day;
  logic             day_wrap;
  logic             mon_inc;
  logic             yr_inc;
  logic             wday_carry_unused;
  logic             yr_carry_unused;

  // Month length depends on the month and year before this edge
  assign last_day = month_len(mon_o, yr_o);
  assign day_wrap = (day_q >= last_day);
  assign mon_inc  = inc_i && day_wrap;
  assign day_o    = day_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        day_q <= 6'h01;
    else if (ld_i[0])  day_q <= ld_day_i;
    else if (inc_i)    day_q <= day_wrap ? 6'h01 : 6'(bcd_inc(8'(day_q)));
  end

  bcd_wrap_counter #(.WIDTH(W_WDAY), .MAXV(3'd6), .MINV(3'd0)) u_wday (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .ld_i(ld_i[1]),
    .ld_val_i(ld_wday_i), .val_o(wday_o), .carry_o(wday_carry_unused)
  );

  bcd_wrap_counter #(.WIDTH(W_MON), .MAXV(5'h12), .MINV(5'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc_i(mon_inc), .ld_i(ld_i[2]),
    .ld_val_i(ld_mon_i), .val_o(mon_o), .carry_o(yr_inc)
  );

  bcd_wrap_counter #(.WIDTH(W_YR), .MAXV(8'h99), .MINV(8'h00)) u_yr (
    .clk(clk), .rst_n(rst_n), .inc_i(yr_inc), .ld_i(ld_i[3]),
    .ld_val_i(ld_yr_i), .val_o(yr_o), .carry_o(yr_carry_unused)
  );
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import bcd_clock_pkg::*;
#(
  parameter int SUBDIV = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 stop_i,
  input  logic                 mode12_i,
  input  logic                 osc_fail_i,
  input  logic [NFIELDS-1:0]   ld_en_i,
  input  logic [NFIELDS*8-1:0] ld_val_i,
  output logic [7:0]           sec_o,
  output logic [7:0]           min_o,
  output logic [7:0]           hr_o,
  output logic [7:0]           day_o,
  output logic [7:0]           wday_o,
  output logic [7:0]           mon_o,
  output logic [7:0]           yr_o
);
  logic any_ld;
  logic adv;
  logic min_inc, hr_inc, day_inc;
  logic bad_q;

  logic [W_SEC-1:0]  sec_v;
  logic [W_MIN-1:0]  min_v;
  logic [W_HR-1:0]   hr_v;
  logic [W_DAY-1:0]  day_v;
  logic [W_WDAY-1:0] wday_v;
  logic [W_MON-1:0]  mon_v;
  logic [W_YR-1:0]   yr_v;

  // Load bits above each field's width are dropped
  logic [13:0] ld_pad_unused;
  assign ld_pad_unused = {ld_val_i[7], ld_val_i[15], ld_val_i[23:22], ld_val_i[31:30],
                          ld_val_i[39:35], ld_val_i[47:45]};

  assign any_ld = |ld_en_i;

  bcd_tick_div #(.SUBDIV(SUBDIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(stop_i),
    .clr_i(any_ld), .adv_o(adv)
  );

  bcd_wrap_counter #(.WIDTH(W_SEC), .MAXV(7'h59), .MINV(7'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc_i(adv), .ld_i(ld_en_i[F_SEC]),
    .ld_val_i(ld_val_i[F_SEC*8 +: W_SEC]), .val_o(sec_v), .carry_o(min_inc)
  );

  bcd_wrap_counter #(.WIDTH(W_MIN), .MAXV(7'h59), .MINV(7'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .inc_i(min_inc), .ld_i(ld_en_i[F_MIN]),
    .ld_val_i(ld_val_i[F_MIN*8 +: W_MIN]), .val_o(min_v), .carry_o(hr_inc)
  );

  bcd_hour_counter u_hr (
    .clk(clk), .rst_n(rst_n), .inc_i(hr_inc), .mode12_i(mode12_i),
    .ld_i(ld_en_i[F_HR]), .ld_val_i(ld_val_i[F_HR*8 +: W_HR]),
    .hr_o(hr_v), .carry_o(day_inc)
  );

  bcd_date_counter u_date (
    .clk(clk), .rst_n(rst_n), .inc_i(day_inc),
    .ld_i({ld_en_i[F_YR], ld_en_i[F_MON], ld_en_i[F_WDAY], ld_en_i[F_DAY]}),
    .ld_day_i(ld_val_i[F_DAY*8 +: W_DAY]),
    .ld_wday_i(ld_val_i[F_WDAY*8 +: W_WDAY]),
    .ld_mon_i(ld_val_i[F_MON*8 +: W_MON]),
    .ld_yr_i(ld_val_i[F_YR*8 +: W_YR]),
    .day_o(day_v), .wday_o(wday_v), .mon_o(mon_v), .yr_o(yr_v)
  );

  // Sticky invalid-time flag: a failure outranks a seconds load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bad_q <= 1'b1;
    else if (osc_fail_i)       bad_q <= 1'b1;
    else if (ld_en_i[F_SEC])   bad_q <= 1'b0;
  end

  assign sec_o  = {bad_q, sec_v};
  assign min_o  = {1'b0, min_v};
  assign hr_o   = {2'b00, hr_v};
  assign day_o  = {2'b00, day_v};
  assign wday_o = {5'b00000, wday_v};
  assign mon_o  = {3'b000, mon_v};
  assign yr_o   = yr_v;
endmodule

// File: rtl/bcd_clock_core_chk.sv
module bcd_clock_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       stop_i,
  input logic       osc_fail_i,
  input logic [6:0] ld_en_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hr_o,
  input logic [7:0] day_o,
  input logic [7:0] wday_o,
  input logic [7:0] mon_o,
  input logic [7:0] yr_o
);
  AST_IDLE_SECONDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && ld_en_i == 7'd0) |=> $stable(sec_o[6:0])); // R2

  AST_STOP_FREEZES_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && ld_en_i == 7'd0) |=> $stable({sec_o[6:0], min_o, hr_o, day_o, wday_o, mon_o, yr_o})); // R8

  AST_FAIL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail_i |=> sec_o[7]); // R10

  AST_SEC_LOAD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en_i[0] && !osc_fail_i) |=> !sec_o[7]); // R10

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (min_o[7] == 1'b0 && hr_o[7:6] == 2'b00 && day_o[7:6] == 2'b00 &&
     wday_o[7:3] == 5'd0 && mon_o[7:5] == 3'd0)); // R9
endmodule

bind bcd_clock_core bcd_clock_core_chk u_chk (.*);

// File: tb/bcd_clock_core_test.sv
module bcd_clock_core_test;
  localparam int SUBDIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        mode12_i = 1'b0;
  logic        osc_fail_i = 1'b0;
  logic [6:0]  ld_en_i = '0;
  logic [55:0] ld_val_i = '0;
  logic [7:0]  sec_o, min_o, hr_o, day_o, wday_o, mon_o, yr_o;

  always #4 clk = ~clk;

  bcd_clock_core #(.SUBDIV(SUBDIV)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .stop_i(stop_i),
    .mode12_i(mode12_i), .osc_fail_i(osc_fail_i), .ld_en_i(ld_en_i),
    .ld_val_i(ld_val_i), .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o),
    .day_o(day_o), .wday_o(wday_o), .mon_o(mon_o), .yr_o(yr_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference time kept in plain binary
  int ms, mm, mh, md, mw, mmo, my;
  bit m12;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hr_byte(input bit twelve, input int h);
    int h12;
    if (!twelve) return bcd(h);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return bcd(h12) | ((h >= 12) ? 8'h20 : 8'h00);
  endfunction

  task automatic model_step();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mw = (mw + 1) % 7; md++;
          if (md > mdays(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, {1'b0, sec_o[6:0]}, bcd(ms));
    chk(req, min_o, bcd(mm));
    chk(req, hr_o, hr_byte(m12, mh));
    chk(req, day_o, bcd(md));
    chk(req, wday_o, 8'(mw));
    chk(req, mon_o, bcd(mmo));
    chk(req, yr_o, bcd(my));
  endtask

  task automatic set_model(input bit t12, input int h, input int mi, input int s,
                           input int d, input int w, input int mo, input int y);
    m12 = t12; mh = h; mm = mi; ms = s; md = d; mw = w; mmo = mo; my = y;
  endtask

  task automatic load_model();
    mode12_i = m12;
    ld_en_i  = 7'h7F;
    ld_val_i = {bcd(my), bcd(mmo), 8'(mw), bcd(md), hr_byte(m12, mh), bcd(mm), bcd(ms)};
    @(negedge clk);
    ld_en_i = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic seconds(input int n);
    for (int i = 0; i < n; i++) begin
      ticks(SUBDIV);
      model_step();
    end
  endtask

  initial begin
    #(8 * 180000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed_use;
    seed_use = $urandom(32'd20211);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", sec_o, 8'h80);
    chk("R1", min_o, 8'h00);
    chk("R1", hr_o, 8'h00);
    chk("R1", day_o, 8'h01);
    chk("R1", wday_o, 8'h00);
    chk("R1", mon_o, 8'h01);
    chk("R1", yr_o, 8'h00);

    // R10 seconds load clears the flag
    set_model(0, 10, 20, 30, 15, 3, 6, 21);
    load_model();
    chk("R10", {7'd0, sec_o[7]}, 8'h00);
    chk_all("R9");

    // R2 divider: SUBDIV pulses per second
    ticks(SUBDIV - 1);
    chk("R2", sec_o, bcd(ms));
    seconds(1);
    chk_all("R2");

    // R10 oscillator failure sets the flag, counting unaffected
    osc_fail_i = 1'b1;
    @(negedge clk);
    osc_fail_i = 1'b0;
    chk("R10", sec_o, 8'h80 | bcd(ms));
    osc_fail_i = 1'b1;
    ld_en_i = 7'h01;
    ld_val_i = '0;
    ld_val_i[7:0] = bcd(ms);
    @(negedge clk);
    osc_fail_i = 1'b0;
    ld_en_i = '0;
    chk("R10", {7'd0, sec_o[7]}, 8'h01);
    ld_en_i = 7'h01;
    @(negedge clk);
    ld_en_i = '0;
    chk("R10", {7'd0, sec_o[7]}, 8'h00);

    // R9 masking of load bytes
    ld_en_i  = 7'h7F;
    ld_val_i = {8'h42, 8'hE9, 8'hFD, 8'hC7, 8'hD3, 8'hA5, 8'hC2};
    @(negedge clk);
    ld_en_i = '0;
    chk("R9", sec_o, 8'h42);
    chk("R9", min_o, 8'h25);
    chk("R9", hr_o, 8'h13);
    chk("R9", day_o, 8'h07);
    chk("R9", wday_o, 8'h05);
    chk("R9", mon_o, 8'h09);
    chk("R9", yr_o, 8'h42);

    // R9 a load on the completing tick drops that advance and restarts the divider
    set_model(0, 5, 6, 7, 8, 2, 3, 4);
    load_model();
    ticks(SUBDIV - 1);
    tick_i = 1'b1;
    ld_en_i = 7'h02;
    ld_val_i = '0;
    ld_val_i[15:8] = bcd(33);
    @(negedge clk);
    tick_i = 1'b0;
    ld_en_i = '0;
    mm = 33;
    chk_all("R9");
    ticks(SUBDIV - 1);
    chk_all("R9");
    seconds(0);
    ticks(1);
    model_step();
    chk_all("R9");

    // R8 stop holds everything and resets the divider
    ticks(SUBDIV - 1);
    stop_i = 1'b1;
    ticks(7);
    chk_all("R8");
    stop_i = 1'b0;
    ticks(SUBDIV - 1);
    chk_all("R8");
    ticks(1);
    model_step();
    chk_all("R8");

    // R3 R5 R7 full rollover in 24-hour mode
    set_model(0, 23, 59, 59, 31, 6, 12, 99);
    load_model();
    seconds(1);
    chk_all("R3");
    chk("R5", yr_o, 8'h00);
    chk("R7", wday_o, 8'h00);

    // R5 thirty-day month
    set_model(0, 23, 59, 59, 30, 1, 4, 10);
    load_model();
    seconds(1);
    chk("R5", mon_o, 8'h05);
    chk("R5", day_o, 8'h01);

    // R6 leap and common February
    set_model(0, 23, 59, 59, 28, 0, 2, 24);
    load_model();
    seconds(1);
    chk("R6", day_o, 8'h29);
    seconds(86400 / 86400 * 0);
    set_model(0, 23, 59, 59, 29, 0, 2, 24);
    load_model();
    seconds(1);
    chk("R6", {day_o[3:0], mon_o[3:0]}, 8'h13);
    set_model(0, 23, 59, 59, 28, 0, 2, 23);
    load_model();
    seconds(1);
    chk("R6", {day_o[3:0], mon_o[3:0]}, 8'h13);

    // R4 twelve-hour transitions
    set_model(1, 23, 59, 59, 9, 4, 7, 30);
    load_model();
    seconds(1);
    chk("R4", hr_o, 8'h12);
    chk("R4", day_o, 8'h10);
    set_model(1, 11, 59, 59, 9, 4, 7, 30);
    load_model();
    seconds(1);
    chk("R4", hr_o, 8'h32);
    chk("R4", day_o, 8'h09);
    set_model(1, 12, 59, 59, 9, 4, 7, 30);
    load_model();
    seconds(1);
    chk("R4", hr_o, 8'h21);
    set_model(1, 0, 59, 59, 9, 4, 7, 30);
    load_model();
    seconds(1);
    chk("R4", hr_o, 8'h01);

    // R2 R3 R4 R5 R6 R7 random starts near boundaries
    for (int it = 0; it < 60; it++) begin
      int mo_r, y_r, d_r;
      mo_r = $urandom_range(1, 12);
      y_r  = $urandom_range(0, 99);
      d_r  = ($urandom_range(0, 1) == 1) ? mdays(mo_r, y_r) : $urandom_range(1, mdays(mo_r, y_r));
      set_model($urandom_range(0, 1), ($urandom_range(0, 1) == 1) ? (($urandom_range(0, 1) == 1) ? 23 : 11) : $urandom_range(0, 23),
                ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59), $urandom_range(40, 59),
                d_r, $urandom_range(0, 6), mo_r, y_r);
      load_model();
      seconds($urandom_range(0, 60));
      chk_all("R2");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule